// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a programmable logic device. A four-wire serial port (test clock, mode select, data in, data out) walks the standard sixteen-state controller. That controller selects one of three data registers, or the instruction register, and places it between the serial input and output. No test-reset pin exists. The controller returns to Test-Logic-Reset either on an active-low power-on reset or when mode select stays high for five test-clock edges.

The boundary register is a chain of cells sitting between the core and the pads. There is one pin cell per pin, with three capture/shift stages and two update stages. There is one macrocell cell per macrocell feedback, with one capture stage and one update stage. Five instructions are decoded:
- a non-intrusive sample/preload;
- external test, where the update stages drive the pads and the macrocell feedback;
- bypass;
- identification readout;
- a high-impedance mode that releases every pad and shortens the path to the bypass bit.

The serial port carries no back-pressure. Every test-clock edge in a shift state moves one bit, so all pins here are plain control and data levels.

Top module: `bscan_tap`

## Requirements
- R1: While `por_n` is low, the controller sits in Test-Logic-Reset with the identification instruction active. The pads then follow the core (`pad_out`=`core_out`, `pad_oe`=`core_oe`, `mc_fb`=`mc_val`) and `tdo_en` is low.
- R2: Five rising test-clock edges with `tms` high bring the controller to Test-Logic-Reset from any state. That state makes the identification instruction active again, undoing a high-impedance or external-test instruction.
- R3: The instruction register is 4 bits wide. Capture-IR loads 4'b0001 (the two low bits read 01), and the value is shifted out least significant bit first.
- R4: Opcode 4'b0110 (identification) selects a 32-bit register that loads the `ID_CODE` parameter in Capture-DR and shifts it out least significant bit first. Bit 0 of that value is 1.
- R5: Opcode 4'b1111 (bypass), and any opcode not listed in R4, R6, R8 or R9, selects a one-bit register. That bit captures 0, and each `tdi` bit appears on `tdo` one shift later.
- R6: Opcode 4'b0011 (sample/preload) selects the boundary chain while the pads keep following the core. Capture-DR loads the chain as follows: bit 3p = `pad_in[p]`, bit 3p+1 = `core_out[p]`, bit 3p+2 = `core_oe[p]`, bit 3·NUM_PINS+m = `mc_val[m]`. Bit 0 is nearest `tdo`, so bits leave in ascending order, and the first bit shifted in from `tdi` ends in bit 0.
- R7: Update stages load from the chain only on the falling test-clock edge in Update-DR. Shifting, pausing and the exit states leave them, and the pads, unchanged.
- R8: Opcode 4'b0000 (external test) drives three outputs from the update stages: `pad_out[p]` from chain bit 3p+1, `pad_oe[p]` from bit 3p+2, and `mc_fb[m]` from bit 3·NUM_PINS+m.
- R9: Opcode 4'b1010 (high impedance) forces every `pad_oe` bit to 0 and selects the one-bit bypass register.
- R10: `tdo` and `tdo_en` change only on falling test-clock edges. `tdo_en` is high only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_en | output | 1 | Drive enable for `tdo`; pad is released when low |
| pad_in | input | NUM_PINS | Values seen at the pads |
| core_out | input | NUM_PINS | Functional output values from the core |
| core_oe | input | NUM_PINS | Functional output enables from the core |
| pad_out | output | NUM_PINS | Output values toward the pads |
| pad_oe | output | NUM_PINS | Output enables toward the pads |
| mc_val | input | NUM_MC | Macrocell feedback values from the core |
| mc_fb | output | NUM_MC | Macrocell feedback delivered to the logic array |

## Verification
The bench builds the block with NUM_PINS=4 and NUM_MC=3, which gives a 15-bit boundary chain. At that size every chain bit is predicted and compared on each boundary scan, and no field position has to be sampled. A single scan therefore exercises both cell types, the chain order across the pin/macrocell seam, and each update bit landing on its pad or feedback output. The default identification value is kept, so the full 32-bit readout is compared after power-on and after a mode-select reset.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  parameter int IR_W = 4;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  typedef struct packed {
    logic in_reset;
    logic cap_dr;
    logic sh_dr;
    logic upd_dr;
    logic cap_ir;
    logic sh_ir;
    logic upd_ir;
  } tap_ctl_t;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUNDARY} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = IR_W'(0);
  localparam logic [IR_W-1:0] OP_SAMPLE  = IR_W'(3);
  localparam logic [IR_W-1:0] OP_IDCODE  = IR_W'(6);
  localparam logic [IR_W-1:0] OP_HIGHZ   = IR_W'(10);
  localparam logic [IR_W-1:0] OP_BYPASS  = '1;
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

  function automatic dr_sel_e decode_dr(logic [IR_W-1:0] op);
    dr_sel_e s;
    if (op == OP_EXTEST || op == OP_SAMPLE) s = DR_BOUNDARY;
    else if (op == OP_IDCODE)               s = DR_IDENT;
    else                                    s = DR_BYPASS;
    return s;
  endfunction

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic     tck,
  input  logic     por_n,
  input  logic     tms,
  output tap_st_e  state,
  output tap_ctl_t ctl
);

  tap_st_e nxt;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_comb begin
    ctl.in_reset = (state == ST_RESET);
    ctl.cap_dr   = (state == ST_CAP_DR);
    ctl.sh_dr    = (state == ST_SH_DR);
    ctl.upd_dr   = (state == ST_UPD_DR);
    ctl.cap_ir   = (state == ST_CAP_IR);
    ctl.sh_ir    = (state == ST_SH_IR);
    ctl.upd_ir   = (state == ST_UPD_IR);
  end

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_ctl_t        ctl,
  output logic            ir_so,
  output logic [IR_W-1:0] op
);

  logic [IR_W-1:0] sr;

  // shift stage works on rising tck
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)          sr <= IR_CAPTURE;
    else if (ctl.cap_ir) sr <= IR_CAPTURE;
    else if (ctl.sh_ir)  sr <= {tdi, sr[IR_W-1:1]};
  end

  // active instruction changes on falling tck only
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)            op <= OP_IDCODE;
    else if (ctl.in_reset) op <= OP_IDCODE;
    else if (ctl.upd_ir)   op <= sr;
  end

  assign ir_so = sr[0];

endmodule

// File: rtl/bscan_pin_cell.sv
module bscan_pin_cell (
  input  logic tck,
  input  logic por_n,
  input  logic si,
  input  logic cap,
  input  logic sh,
  input  logic upd,
  input  logic pad_val,
  input  logic drv_val,
  input  logic en_val,
  output logic so,
  output logic u_out,
  output logic u_oe
);

  logic c_in, c_out, c_oe;

  // order toward tdo: c_oe -> c_out -> c_in
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      c_in  <= 1'b0;
      c_out <= 1'b0;
      c_oe  <= 1'b0;
    end else if (cap) begin
      c_in  <= pad_val;
      c_out <= drv_val;
      c_oe  <= en_val;
    end else if (sh) begin
      c_oe  <= si;
      c_out <= c_oe;
      c_in  <= c_out;
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      u_out <= 1'b0;
      u_oe  <= 1'b0;
    end else if (upd) begin
      u_out <= c_out;
      u_oe  <= c_oe;
    end
  end

  assign so = c_in;

endmodule

// File: rtl/bscan_mc_cell.sv
module bscan_mc_cell (
  input  logic tck,
  input  logic por_n,
  input  logic si,
  input  logic cap,
  input  logic sh,
  input  logic upd,
  input  logic mc_in,
  output logic so,
  output logic u_val
);

  logic c_val;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)   c_val <= 1'b0;
    else if (cap) c_val <= mc_in;
    else if (sh)  c_val <= si;
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)   u_val <= 1'b0;
    else if (upd) u_val <= c_val;
  end

  assign so = c_val;

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int          NUM_PINS = 8,
  parameter int          NUM_MC   = 4,
  parameter logic [31:0] ID_CODE  = 32'h1A5C_E03F
) (
  input  logic                tck,
  input  logic                por_n,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  output logic                tdo_en,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_MC-1:0]   mc_val,
  output logic [NUM_MC-1:0]   mc_fb
);

  localparam int NUM_CELLS = NUM_PINS + NUM_MC;
  localparam int ID_W      = 32;

  tap_st_e         st;
  tap_ctl_t        ctl;
  logic            ir_so;
  logic [IR_W-1:0] cur_op;
  dr_sel_e         dsel;

  bscan_fsm u_fsm (
    .tck   (tck),
    .por_n (por_n),
    .tms   (tms),
    .state (st),
    .ctl   (ctl)
  );

  bscan_ir u_ir (
    .tck   (tck),
    .por_n (por_n),
    .tdi   (tdi),
    .ctl   (ctl),
    .ir_so (ir_so),
    .op    (cur_op)
  );

  assign dsel = decode_dr(cur_op);

  // boundary chain gating
  logic bsr_cap, bsr_sh, bsr_upd;
  assign bsr_cap = ctl.cap_dr && (dsel == DR_BOUNDARY);
  assign bsr_sh  = ctl.sh_dr  && (dsel == DR_BOUNDARY);
  assign bsr_upd = ctl.upd_dr && (dsel == DR_BOUNDARY);

  // link[k+1] feeds cell k, cell 0 drives link[0] toward tdo
  logic [NUM_CELLS:0]  link;
  logic [NUM_PINS-1:0] pin_uo, pin_uoe;
  logic [NUM_MC-1:0]   mc_u;

  assign link[NUM_CELLS] = tdi;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    bscan_pin_cell u_cell (
      .tck     (tck),
      .por_n   (por_n),
      .si      (link[p+1]),
      .cap     (bsr_cap),
      .sh      (bsr_sh),
      .upd     (bsr_upd),
      .pad_val (pad_in[p]),
      .drv_val (core_out[p]),
      .en_val  (core_oe[p]),
      .so      (link[p]),
      .u_out   (pin_uo[p]),
      .u_oe    (pin_uoe[p])
    );
  end

  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    bscan_mc_cell u_cell (
      .tck   (tck),
      .por_n (por_n),
      .si    (link[NUM_PINS+m+1]),
      .cap   (bsr_cap),
      .sh    (bsr_sh),
      .upd   (bsr_upd),
      .mc_in (mc_val[m]),
      .so    (link[NUM_PINS+m]),
      .u_val (mc_u[m])
    );
  end

  // bypass bit and identification register
  logic            byp_q;
  logic [ID_W-1:0] id_sr;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q <= 1'b0;
      id_sr <= ID_CODE;
    end else begin
      if (ctl.cap_dr && dsel == DR_BYPASS)     byp_q <= 1'b0;
      else if (ctl.sh_dr && dsel == DR_BYPASS) byp_q <= tdi;
      if (ctl.cap_dr && dsel == DR_IDENT)      id_sr <= ID_CODE;
      else if (ctl.sh_dr && dsel == DR_IDENT)  id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  logic dr_so;
  always_comb begin
    unique case (dsel)
      DR_BOUNDARY: dr_so = link[0];
      DR_IDENT:    dr_so = id_sr[0];
      default:     dr_so = byp_q;
    endcase
  end

  // serial output launched on falling tck
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (st == ST_SH_DR) || (st == ST_SH_IR);
      tdo    <= (st == ST_SH_IR) ? ir_so : dr_so;
    end
  end

  // pad and feedback steering
  always_comb begin
    pad_out = core_out;
    pad_oe  = core_oe;
    mc_fb   = mc_val;
    if (cur_op == OP_EXTEST) begin
      pad_out = pin_uo;
      pad_oe  = pin_uoe;
      mc_fb   = mc_u;
    end else if (cur_op == OP_HIGHZ) begin
      pad_oe  = '0;
    end
  end

endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
  import bscan_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_MC   = 4
) (
  input logic                tck,
  input logic                por_n,
  input logic                tms,
  input logic                tdi,
  input tap_st_e             state,
  input logic [IR_W-1:0]     op,
  input logic                tdo_en,
  input logic                byp,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pin_uo,
  input logic [NUM_PINS-1:0] pin_uoe,
  input logic [NUM_MC-1:0]   mc_u
);

  logic [2:0] ones_run;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)             ones_run <= 3'd0;
    else if (!tms)          ones_run <= 3'd0;
    else if (ones_run < 5)  ones_run <= ones_run + 3'd1;
  end

  // R2: five high tms edges reach Test-Logic-Reset
  p_tms_reset_r2: assert property (@(posedge tck) disable iff (!por_n)
    (ones_run >= 3'd5) |-> (state == ST_RESET));

  // R1: reset state makes identification active
  p_ident_in_reset_r1: assert property (@(negedge tck) disable iff (!por_n)
    (state == ST_RESET) |=> (op == OP_IDCODE));

  // R5: bypass bit follows tdi by one shift
  p_bypass_delay_r5: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_SH_DR && decode_dr(op) == DR_BYPASS) |=> (byp == $past(tdi)));

  // R7: update stages move only from Update-DR
  p_update_window_r7: assert property (@(negedge tck) disable iff (!por_n)
    (state != ST_UPD_DR) |=> $stable({pin_uo, pin_uoe, mc_u}));

  // R9: high impedance releases all pads
  p_highz_release_r9: assert property (@(posedge tck) disable iff (!por_n)
    (op == OP_HIGHZ) |-> (pad_oe == '0));

  // R10: serial driver only in shift states
  p_tdo_window_r10: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind bscan_tap bscan_tap_chk #(.NUM_PINS(NUM_PINS), .NUM_MC(NUM_MC)) u_chk (
  .tck     (tck),
  .por_n   (por_n),
  .tms     (tms),
  .tdi     (tdi),
  .state   (st),
  .op      (cur_op),
  .tdo_en  (tdo_en),
  .byp     (byp_q),
  .pad_oe  (pad_oe),
  .pin_uo  (pin_uo),
  .pin_uoe (pin_uoe),
  .mc_u    (mc_u)
);

// File: tb/bscan_tap_bench.sv
module bscan_tap_bench;

  localparam int          NP  = 4;
  localparam int          NM  = 3;
  localparam int          LEN = 3 * NP + NM;
  localparam logic [31:0] IDV = 32'h1A5C_E03F;

  logic tck = 1'b0;
  logic por_n, tms, tdi;
  logic tdo, tdo_en;
  logic [NP-1:0] pad_in, core_out, core_oe, pad_out, pad_oe;
  logic [NM-1:0] mc_val, mc_fb;

  always #4 tck = ~tck;

  bscan_tap #(.NUM_PINS(NP), .NUM_MC(NM), .ID_CODE(IDV)) u_bscan_tap (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .mc_val(mc_val), .mc_fb(mc_fb)
  );

  int checks = 0;
  int errors = 0;

  typedef struct { logic v; string tag; } exp_t;
  exp_t exp_q[$];
  logic mon_en = 1'b0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected serial bits and compares
  initial begin
    forever begin
      logic held;
      exp_t it;
      @(negedge tck); #3;
      if (mon_en) begin
        held = tdo;
        if (exp_q.size() == 0) chk("R10", "unexpected sample", 64'(tdo), 64'(1'bx));
        else begin
          it = exp_q.pop_front();
          chk(it.tag, "tdo bit", 64'(tdo), 64'(it.v));
        end
        chk("R10", "tdo_en in shift", 64'(tdo_en), 64'(1'b1));
        @(posedge tck); #1;
        chk("R10", "tdo held across rising edge", 64'(tdo), 64'(held));
      end
    end
  end

  task automatic tick(logic m, logic d, logic c, logic e, string tag);
    exp_t it;
    @(negedge tck); #2;
    tms = m; tdi = d; mon_en = c;
    if (c) begin it.v = e; it.tag = tag; exp_q.push_back(it); end
  endtask

  task automatic goto_shift(logic ir);
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    if (ir) tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic shift_bits(int len, logic [63:0] din, logic [63:0] dexp, logic [63:0] dmask, string tag);
    for (int i = 0; i < len; i++)
      tick(i == len - 1, din[i], dmask[i], dexp[i], tag);
  endtask

  task automatic exit_update();
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic settle();
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    @(negedge tck); #3;
  endtask

  task automatic load_ir(logic [3:0] code);
    goto_shift(1'b1);
    shift_bits(4, 64'(code), 64'h1, 64'hF, "R3");
    exit_update();
  endtask

  task automatic scan_dr(int len, logic [63:0] din, logic [63:0] dexp, string tag);
    goto_shift(1'b0);
    shift_bits(len, din, dexp, (64'h1 << len) - 64'h1, tag);
    exit_update();
  endtask

  function automatic logic [63:0] img(logic [NP-1:0] pi, logic [NP-1:0] po,
                                      logic [NP-1:0] pe, logic [NM-1:0] mv);
    logic [63:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      r[3*p] = pi[p]; r[3*p+1] = po[p]; r[3*p+2] = pe[p];
    end
    for (int m = 0; m < NM; m++) r[3*NP+m] = mv[m];
    return r;
  endfunction

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] pre, cap, nxt, cap2;
    por_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    pad_in = 4'b0110; core_out = 4'b1100; core_oe = 4'b1010; mc_val = 3'b101;
    repeat (3) @(negedge tck);
    #2 por_n = 1'b1;
    @(negedge tck); #3;
    // R1 reset state
    chk("R10", "tdo_en after reset", 64'(tdo_en), 64'(1'b0));
    chk("R1", "pad_out functional", 64'(pad_out), 64'(core_out));
    chk("R1", "pad_oe functional", 64'(pad_oe), 64'(core_oe));
    chk("R1", "mc_fb functional", 64'(mc_fb), 64'(mc_val));
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    scan_dr(32, 64'h0, 64'(IDV), "R1");          // identification active at reset
    scan_dr(32, 64'hDEAD_BEEF, 64'(IDV), "R4");  // recaptured each scan
    settle();
    chk("R10", "tdo_en idle", 64'(tdo_en), 64'(1'b0));

    // R6 sample/preload
    load_ir(4'b0011);
    cap = img(pad_in, core_out, core_oe, mc_val);
    pre = img(4'b0000, 4'b0101, 4'b0011, 3'b011);
    scan_dr(LEN, pre, cap, "R6");
    settle();
    chk("R6", "pad_out stays functional", 64'(pad_out), 64'(core_out));
    chk("R6", "pad_oe stays functional", 64'(pad_oe), 64'(core_oe));
    chk("R6", "mc_fb stays functional", 64'(mc_fb), 64'(mc_val));

    // R8 external test uses preloaded values
    load_ir(4'b0000);
    settle();
    chk("R8", "pad_out from update", 64'(pad_out), 64'(4'b0101));
    chk("R8", "pad_oe from update", 64'(pad_oe), 64'(4'b0011));
    chk("R8", "mc_fb from update", 64'(mc_fb), 64'(3'b011));

    // R7 shift then pause: no change until Update-DR
    pad_in = 4'b1001;
    cap2 = img(pad_in, core_out, core_oe, mc_val);
    nxt  = img(4'b0000, 4'b1001, 4'b1110, 3'b110);
    goto_shift(1'b0);
    shift_bits(LEN, nxt, cap2, (64'h1 << LEN) - 64'h1, "R7");
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");   // to Pause-DR
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    @(negedge tck); #3;
    chk("R7", "pad_out held in pause", 64'(pad_out), 64'(4'b0101));
    chk("R7", "pad_oe held in pause", 64'(pad_oe), 64'(4'b0011));
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");   // Exit2-DR
    tick(1'b1, 1'b0, 1'b0, 1'b0, "");   // Update-DR
    settle();
    chk("R7", "pad_out after update", 64'(pad_out), 64'(4'b1001));
    chk("R8", "pad_oe after update", 64'(pad_oe), 64'(4'b1110));
    chk("R8", "mc_fb after update", 64'(mc_fb), 64'(3'b110));

    // R2 mode-select reset from idle undoes external test
    repeat (5) tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    @(negedge tck); #3;
    chk("R2", "pad_out after tms reset", 64'(pad_out), 64'(core_out));
    chk("R2", "pad_oe after tms reset", 64'(pad_oe), 64'(core_oe));
    tick(1'b0, 1'b0, 1'b0, 1'b0, "");
    scan_dr(32, 64'h0, 64'(IDV), "R2");

    // R5 bypass and an undefined opcode
    load_ir(4'b1111);
    scan_dr(8, 64'hB2, 64'hB2 << 1, "R5");
    settle();
    chk("R5", "pad_out functional in bypass", 64'(pad_out), 64'(core_out));
    load_ir(4'b0101);
    scan_dr(6, 64'h35, (64'h35 << 1) & 64'h3F, "R5");

    // R9 high impedance
    core_oe = 4'b1111;
    load_ir(4'b1010);
    settle();
    chk("R9", "pad_oe released", 64'(pad_oe), 64'(4'b0000));
    scan_dr(5, 64'h0D, (64'h0D << 1) & 64'h1F, "R9");

    // R2 abort from the middle of Shift-IR
    goto_shift(1'b1);
    tick(1'b0, 1'b1, 1'b1, 1'b1, "R3");
    tick(1'b0, 1'b1, 1'b1, 1'b0, "R3");
    repeat (5) tick(1'b1, 1'b0, 1'b0, 1'b0, "");
    @(negedge tck); #3;
    chk("R2", "pad_oe after abort reset", 64'(pad_oe), 64'(core_oe));
    chk("R10", "tdo_en in reset", 64'(tdo_en), 64'(1'b0));

    repeat (2) @(negedge tck);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule